// File: doc/BRIEF.md
# Floating-point status register unit

This block holds the 32-bit status and control word of a floating-point pipeline. The arithmetic datapath classifies its operands and results elsewhere and reports them here through three update paths. A set-exception strobe ORs a mask of sticky flag bits into the word. A class strobe replaces the 5-bit result-class field. A software strobe loads the whole word. Bits are numbered MSB-first, so architectural bit 0 is the MSB, stored at vector index 31.

Every update keeps the two summary bits coherent. The exception summary (index 31) latches only when a flag or invalid-cause bit goes from 0 to 1 in that update. The invalid summary (index 29) is always the OR of the nine invalid-cause bits. Readback gives the raw word, the 2-bit rounding mode from indices 1:0, and a 4-bit condition summary for the compare logic. All inputs are plain per-cycle strobes with no handshake. The unit accepts one of each every cycle and never applies back-pressure. Results appear on the outputs one clock after the strobe.

Top module: `fpsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the word to 0x00000000. This gives rounding mode 00 (nearest-even) and a condition summary of 0000.
- R2: With exc_set high, these bits of exc_mask are ORed into the word:
  - overflow (index 28), underflow (27), zero-divide (26) and inexact (25);
  - invalid causes at indices 24, 23, 22, 21, 20, 19, 10, 9 and 8;
  - fraction-rounded (18) and fraction-inexact (17).
  All other mask bits are ignored. These are indices 31, 30, 29, 16:12, 11, 7:0 and 1:0.
- R3: The exception summary (index 31) is set when an update turns any of indices 28..25, or any invalid-cause bit, from 0 to 1. Re-asserting a bit that is already 1 does not set it. After software clears index 31 and index 28, raising index 28 again sets index 31 again.
- R4: After every update, index 29 equals the OR of the nine invalid-cause bits. This includes a software write, whose own value for index 29 is discarded.
- R5: With cls_we high, cls_value replaces indices 16:12 and every other bit is kept.
- R6: With sw_we high, sw_wdata is loaded into every bit except index 29 (see R4).
- R7: When several strobes fall in one cycle, the software write is applied first, then the class write, then the exception mask. The 0-to-1 test of R3 is made against the value after the writes.
- R8: rnd_mode equals indices 1:0 of the word. The codes are 00 nearest-even, 01 toward zero, 10 toward plus infinity and 11 toward minus infinity.
- R9: cond_flags[3:0] is {lt, gt, eq, so}, taken from word indices {31, 30, 29, 28} respectively.
- R10: A cycle with no strobe leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software full-word write strobe |
| sw_wdata | input | 32 | Software write data |
| cls_we | input | 1 | Result-class write strobe |
| cls_value | input | 5 | Result class for indices 16:12 |
| exc_set | input | 1 | Set-exception strobe |
| exc_mask | input | 32 | Exception bits to OR in |
| fpsr_q | output | 32 | Current register word |
| rnd_mode | output | 2 | Decoded rounding mode |
| cond_flags | output | 4 | {lt, gt, eq, so} condition summary |

## Verification
A software write and a set-exception request can land in the same cycle, and that is the interaction that matters. It decides whether the exception summary latches. Directed cases provoke it in two ways. One writes a word that already holds the overflow bit while raising overflow, so the summary must stay clear. The other writes zero while raising zero-divide, so the summary must latch. The random phase also overlaps all three strobes frequently. Each result is judged against a bench model that applies the stated order: write, then class, then mask.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

  localparam int REG_W     = 32;
  localparam int CLS_W     = 5;
  localparam int CLS_LSB   = 12;
  localparam int RM_W      = 2;
  localparam int COND_W    = 4;
  localparam int NUM_CAUSE = 9;

  localparam int POS_FX  = 31;
  localparam int POS_FEX = 30;
  localparam int POS_VX  = 29;
  localparam int POS_OX  = 28;
  localparam int POS_UX  = 27;
  localparam int POS_ZX  = 26;
  localparam int POS_XX  = 25;
  localparam int POS_FR  = 18;
  localparam int POS_FI  = 17;

  localparam int CAUSE_POS [NUM_CAUSE] = '{24, 23, 22, 21, 20, 19, 10, 9, 8};

  typedef enum logic [RM_W-1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_PINF    = 2'b10,
    RM_NINF    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  function automatic logic [REG_W-1:0] build_cause_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CAUSE; i++) m[CAUSE_POS[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] build_flag_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[POS_OX] = 1'b1;
    m[POS_UX] = 1'b1;
    m[POS_ZX] = 1'b1;
    m[POS_XX] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] build_class_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < CLS_W; i++) m[CLS_LSB + i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] CAUSE_MASK  = build_cause_mask();
  localparam logic [REG_W-1:0] FLAG_MASK   = build_flag_mask();
  localparam logic [REG_W-1:0] STICKY_MASK = CAUSE_MASK | FLAG_MASK;
  localparam logic [REG_W-1:0] CLASS_MASK  = build_class_mask();
  localparam logic [REG_W-1:0] SET_MASK    =
    STICKY_MASK | (REG_W'(1) << POS_FR) | (REG_W'(1) << POS_FI);

endpackage

// File: rtl/fpsr_merge.sv
module fpsr_merge
  import fpsr_pkg::*;
(
  input  logic [REG_W-1:0] cur_q,
  input  logic             sw_we,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             cls_we,
  input  logic [CLS_W-1:0] cls_value,
  output logic [REG_W-1:0] merged
);

  logic [REG_W-1:0] after_sw;

  // Software write first, then the class field on top of it.
  always_comb begin
    after_sw = sw_we ? sw_wdata : cur_q;
    merged   = after_sw;
    if (cls_we) begin
      merged[CLS_LSB +: CLS_W] = cls_value;
    end
  end

endmodule

// File: rtl/fpsr_except.sv
module fpsr_except
  import fpsr_pkg::*;
(
  input  logic [REG_W-1:0] base,
  input  logic             exc_set,
  input  logic [REG_W-1:0] exc_mask,
  output logic [REG_W-1:0] next_q
);

  logic [REG_W-1:0]     new_bits;
  logic [REG_W-1:0]     ored;
  logic [REG_W-1:0]     rising;
  logic [NUM_CAUSE-1:0] cause_v;

  assign new_bits = exc_set ? (exc_mask & SET_MASK) : '0;
  assign ored     = base | new_bits;
  assign rising   = new_bits & ~base & STICKY_MASK;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    assign cause_v[g] = ored[CAUSE_POS[g]];
  end

  always_comb begin
    next_q         = ored;
    next_q[POS_FX] = ored[POS_FX] | (|rising);
    next_q[POS_VX] = |cause_v;
  end

endmodule

// File: rtl/fpsr_readout.sv
module fpsr_readout
  import fpsr_pkg::*;
(
  input  logic [COND_W-1:0] top_bits,
  input  logic [RM_W-1:0]   rm_bits,
  output logic [RM_W-1:0]   rnd_mode,
  output logic [COND_W-1:0] cond_flags
);

  rmode_e mode;
  cond_t  cf;

  always_comb begin
    unique case (rm_bits)
      2'b00:   mode = RM_NEAREST;
      2'b01:   mode = RM_ZERO;
      2'b10:   mode = RM_PINF;
      default: mode = RM_NINF;
    endcase
  end

  // top_bits carries word indices 31..28: FX, FEX, VX, OX.
  always_comb begin
    cf.lt = top_bits[3];
    cf.gt = top_bits[2];
    cf.eq = top_bits[1];
    cf.so = top_bits[0];
  end

  assign rnd_mode   = mode;
  assign cond_flags = cf;

endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [REG_W-1:0]  sw_wdata,
  input  logic              cls_we,
  input  logic [CLS_W-1:0]  cls_value,
  input  logic              exc_set,
  input  logic [REG_W-1:0]  exc_mask,
  output logic [REG_W-1:0]  fpsr_q,
  output logic [RM_W-1:0]   rnd_mode,
  output logic [COND_W-1:0] cond_flags
);

  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] next_q;
  logic             any_upd;

  fpsr_merge u_merge (
    .cur_q     (word_q),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .cls_we    (cls_we),
    .cls_value (cls_value),
    .merged    (merged)
  );

  fpsr_except u_except (
    .base     (merged),
    .exc_set  (exc_set),
    .exc_mask (exc_mask),
    .next_q   (next_q)
  );

  assign any_upd = sw_we | cls_we | exc_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (any_upd) begin
      word_q <= next_q;
    end
  end

  fpsr_readout u_readout (
    .top_bits   (word_q[REG_W-1 -: COND_W]),
    .rm_bits    (word_q[RM_W-1:0]),
    .rnd_mode   (rnd_mode),
    .cond_flags (cond_flags)
  );

  assign fpsr_q = word_q;

endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk
  import fpsr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sw_we,
  input logic [REG_W-1:0]  sw_wdata,
  input logic              cls_we,
  input logic [CLS_W-1:0]  cls_value,
  input logic              exc_set,
  input logic [REG_W-1:0]  exc_mask,
  input logic [REG_W-1:0]  fpsr_q,
  input logic [RM_W-1:0]   rnd_mode,
  input logic [COND_W-1:0] cond_flags
);

  localparam logic [REG_W-1:0] VX_BIT = REG_W'(1) << POS_VX;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (fpsr_q == '0));

  assert_sticky_or_R2: assert property (@(posedge clk) disable iff (rst)
    exc_set |=> ((fpsr_q & $past(exc_mask & STICKY_MASK)) == $past(exc_mask & STICKY_MASK)));

  assert_fx_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(fpsr_q[POS_FX]) && !$past(sw_we)) |-> $past(exc_set));

  assert_vx_summary_R4: assert property (@(posedge clk) disable iff (rst)
    fpsr_q[POS_VX] == (|(fpsr_q & CAUSE_MASK)));

  assert_class_field_R5: assert property (@(posedge clk) disable iff (rst)
    cls_we |=> (fpsr_q[CLS_LSB +: CLS_W] == $past(cls_value)));

  assert_class_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (cls_we && !sw_we && !exc_set) |=> ((fpsr_q & ~CLASS_MASK) == $past(fpsr_q & ~CLASS_MASK)));

  assert_sw_load_R6: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !cls_we && !exc_set) |=> ((fpsr_q & ~VX_BIT) == $past(sw_wdata & ~VX_BIT)));

  assert_rmode_R8: assert property (@(posedge clk) disable iff (rst)
    rnd_mode == fpsr_q[1:0]);

  assert_cond_R9: assert property (@(posedge clk) disable iff (rst)
    cond_flags == {fpsr_q[POS_FX], fpsr_q[POS_FEX], fpsr_q[POS_VX], fpsr_q[POS_OX]});

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !cls_we && !exc_set) |=> $stable(fpsr_q));

endmodule

bind fpsr_unit fpsr_unit_chk chk_i (.*);

// File: tb/fpsr_unit_tb_top.sv
`timescale 1ns/1ps
module fpsr_unit_tb_top;

  localparam logic [31:0] CAUSES = 32'h01F8_0700;
  localparam logic [31:0] STICKY = 32'h1E00_0000 | CAUSES;
  localparam logic [31:0] SETTBL = STICKY | 32'h0006_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_we;
  logic [31:0] sw_wdata;
  logic        cls_we;
  logic [4:0]  cls_value;
  logic        exc_set;
  logic [31:0] exc_mask;
  logic [31:0] fpsr_q;
  logic [1:0]  rnd_mode;
  logic [3:0]  cond_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model_q;

  always #4 clk = ~clk;

  fpsr_unit dut_i (
    .clk        (clk),
    .rst        (rst),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .cls_we     (cls_we),
    .cls_value  (cls_value),
    .exc_set    (exc_set),
    .exc_mask   (exc_mask),
    .fpsr_q     (fpsr_q),
    .rnd_mode   (rnd_mode),
    .cond_flags (cond_flags)
  );

  function automatic logic [31:0] expect_next(input logic [31:0] q, input logic sw,
      input logic [31:0] wd, input logic cw, input logic [4:0] cv,
      input logic ex, input logic [31:0] m);
    logic [31:0] b, nb, r;
    b = sw ? wd : q;
    if (cw) b[16:12] = cv;
    nb = ex ? (m & SETTBL) : 32'h0;
    r  = b | nb;
    if ((nb & ~b & STICKY) != 32'h0) r[31] = 1'b1;
    r[29] = |(r & CAUSES);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic sw, input logic [31:0] wd, input logic cw,
      input logic [4:0] cv, input logic ex, input logic [31:0] m);
    string tag;
    @(negedge clk);
    sw_we = sw; sw_wdata = wd; cls_we = cw; cls_value = cv; exc_set = ex; exc_mask = m;
    model_q = expect_next(model_q, sw, wd, cw, cv, ex, m);
    @(posedge clk);
    #1;
    if (sw && ex)      tag = "R7";
    else if (ex)       tag = "R3";
    else if (cw)       tag = "R5";
    else if (sw)       tag = "R6";
    else               tag = "R10";
    chk(tag, fpsr_q, model_q);
    chk("R8", {30'h0, rnd_mode}, {30'h0, model_q[1:0]});
    chk("R9", {28'h0, cond_flags}, {28'h0, model_q[31], model_q[30], model_q[29], model_q[28]});
    @(negedge clk);
    sw_we = 1'b0; cls_we = 1'b0; exc_set = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250517));
    rst = 1'b1; sw_we = 1'b0; sw_wdata = '0; cls_we = 1'b0; cls_value = '0;
    exc_set = 1'b0; exc_mask = '0; model_q = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", fpsr_q, 32'h0);
    chk("R1", {30'h0, rnd_mode}, 32'h0);
    chk("R1", {28'h0, cond_flags}, 32'h0);

    // R3: overflow raises FX; cond shows lt and so
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h1000_0000);
    chk("R3", fpsr_q, 32'h9000_0000);
    chk("R9", {28'h0, cond_flags}, 32'h9);
    step(1'b1, 32'h0, 1'b0, 5'h0, 1'b0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h1000_0000);
    chk("R3", fpsr_q, 32'h9000_0000);
    // R3: re-asserting a set bit does not raise FX
    step(1'b1, 32'h1000_0000, 1'b0, 5'h0, 1'b0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h1000_0000);
    chk("R3", fpsr_q, 32'h1000_0000);
    // R4: invalid summary
    step(1'b1, 32'h0, 1'b0, 5'h0, 1'b0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h0100_0000);
    chk("R4", fpsr_q, 32'hA100_0000);
    step(1'b1, 32'h2000_0000, 1'b0, 5'h0, 1'b0, 32'h0);
    chk("R4", fpsr_q, 32'h0);
    step(1'b1, 32'h0000_0400, 1'b0, 5'h0, 1'b0, 32'h0);
    chk("R4", fpsr_q, 32'h2000_0400);
    // R5 / R6
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'h0, 1'b0, 32'h0);
    chk("R6", fpsr_q, 32'hFFFF_FFFF);
    step(1'b0, 32'h0, 1'b1, 5'h04, 1'b0, 32'h0);
    chk("R5", fpsr_q, 32'hFFFE_4FFF);
    // R8: all rounding codes
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 32'(k), 1'b0, 5'h0, 1'b0, 32'h0);
      chk("R8", {30'h0, rnd_mode}, 32'(k));
    end
    // R7: same-cycle write and exception
    step(1'b1, 32'h1000_0000, 1'b0, 5'h0, 1'b1, 32'h1000_0000);
    chk("R7", fpsr_q, 32'h1000_0000);
    step(1'b1, 32'h0, 1'b0, 5'h0, 1'b1, 32'h0400_0000);
    chk("R7", fpsr_q, 32'h8400_0000);
    step(1'b1, 32'h0, 1'b1, 5'h11, 1'b1, 32'h0001_F000);
    chk("R7", fpsr_q, 32'h0001_1000);
    // R2: non-settable mask bits ignored
    step(1'b1, 32'h0, 1'b0, 5'h0, 1'b0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'hE001_F8FF);
    chk("R2", fpsr_q, 32'h0);
    step(1'b0, 32'h0, 1'b0, 5'h0, 1'b1, 32'h0006_0000);
    chk("R2", fpsr_q, 32'h0006_0000);
    // R10: idle holds
    step(1'b0, 32'hDEAD_BEEF, 1'b0, 5'h1F, 1'b0, 32'hFFFF_FFFF);
    chk("R10", fpsr_q, 32'h0006_0000);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic sw, cw, ex;
      logic [31:0] wd, m;
      logic [4:0] cv;
      sw = ($urandom % 8) == 0;
      cw = ($urandom % 4) == 0;
      ex = ($urandom % 2) == 0;
      wd = $urandom & $urandom;
      m  = $urandom & $urandom & $urandom;
      cv = 5'($urandom);
      step(sw, wd, cw, cv, ex, m);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule